// File: doc/BRIEF.md
# Clock-Stretching Shared RAM Arbiter

This block shares one 16 KB RAM between a display fetch engine and an 8-bit CPU whose bus carries separate memory-request, I/O-request, read and write strobes, all active low. The display side owns the RAM the moment it asks for it. A CPU memory access that targets the shared window while the display is fetching is held off. The block does this by freezing the clock it supplies to the CPU in its low phase. No wait line is used.

The CPU clock is made here by halving the master clock. Its high phase always lasts exactly one master cycle, and a freeze can only extend a low phase, so the CPU never sees a shortened pulse. The block also decodes I/O cycles from the low address byte through a mask and match pair. It raises a periodic active-low frame interrupt whose period is a parameter counted in master cycles. That interrupt is released after a fixed number of CPU clock periods.

Top module: `shared_ram_arbiter`

## Requirements
- R1: While rst_n is low, cpu_clk is 0, int_n is 1 and ram_we is 0.
- R2: With no contention, cpu_clk toggles on every master clock edge, so each high and each low phase lasts one master cycle.
- R3: While vid_req is 1, vid_gnt is 1 in the same cycle, ram_addr equals vid_addr, vid_rdata carries the RAM data, and ram_we is 0.
- R4: A CPU cycle is contended when mreq_n is 0, cpu_addr[15:14] equals 2'b01 (0x4000 to 0x7FFF) and vid_req is 1. While contended, cpu_clk is held at 0. If contention begins during a high phase, that phase still ends after its one master cycle.
- R5: A memory cycle outside the window, or any cycle with mreq_n high, is never stretched, even while vid_req is 1.
- R6: The master clock edge that first samples vid_req at 0 during a frozen low phase drives cpu_clk to 1.
- R7: With vid_req 0, a window write (mreq_n 0, wr_n 0, rd_n 1) drives ram_we 1, ram_addr = cpu_addr[13:0] and ram_wdata = cpu_wdata. A window read returns the RAM data on cpu_rdata.
- R8: With iorq_n 0, an I/O cycle is selected when (cpu_addr[7:0] & 8'h01) == 8'h00. io_rd follows rd_n and io_wr follows wr_n for a selected cycle. cpu_addr[15:8] has no effect on selection.
- R9: When rd_n and wr_n are both 0, ram_we, io_rd and io_wr all stay 0.
- R10: int_n falls once every FRAME_DIV master cycles.
- R11: Once low, int_n returns to 1 on the edge that produces the INT_CYCLES-th rising edge of cpu_clk, whether or not the clock is frozen in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | Data driven by the CPU |
| cpu_rdata | output | 8 | Data returned to the CPU from RAM |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cpu_clk | output | 1 | Gated CPU clock |
| int_n | output | 1 | Frame interrupt, active low |
| io_rd | output | 1 | Selected I/O read strobe |
| io_wr | output | 1 | Selected I/O write strobe |
| vid_req | input | 1 | Display fetch request |
| vid_addr | input | 14 | Display fetch address |
| vid_gnt | output | 1 | Display fetch grant |
| vid_rdata | output | 8 | RAM data to the display side |
| ram_addr | output | 14 | RAM address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |

## Verification
A wrong clock state shows up on cpu_clk one master edge later. The clock either rises during contention, runs past a one-cycle high phase, or stays low after the display releases the RAM. Wrong frame or length counters show up on int_n: the spacing between its falling edges drifts from FRAME_DIV, or the number of CPU clock rises inside a low pulse differs from INT_CYCLES. The bench freezes the clock partway through a pulse so that a length counter which tracks master cycles instead of CPU rises is caught. A wrong grant, address path or strobe decode is visible combinationally in the same cycle as the stimulus.

// File: rtl/shared_ram_arbiter.sv
module shared_ram_arbiter #(
  parameter int          CPU_AW     = 16,
  parameter int          RAM_AW     = 14,
  parameter int          DW         = 8,
  parameter int          WIN_PAGE   = 1,
  parameter logic [7:0]  IO_MASK    = 8'h01,
  parameter logic [7:0]  IO_MATCH   = 8'h00,
  parameter int          FRAME_DIV  = 280000,
  parameter int          INT_CYCLES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic [DW-1:0]     cpu_rdata,
  input  logic              mreq_n,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic              cpu_clk,
  output logic              int_n,
  output logic              io_rd,
  output logic              io_wr,
  input  logic              vid_req,
  input  logic [RAM_AW-1:0] vid_addr,
  output logic              vid_gnt,
  output logic [DW-1:0]     vid_rdata,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_we,
  output logic [DW-1:0]     ram_wdata,
  input  logic [DW-1:0]     ram_rdata
);

  localparam int PAGE_W = CPU_AW - RAM_AW;
  localparam int FW     = $clog2(FRAME_DIV);
  localparam int IW     = $clog2(INT_CYCLES + 1);

  logic          in_win, contended, hold, cpu_rise, io_sel, frame_tick;
  logic [FW-1:0] fcnt;
  logic [IW-1:0] icnt;

  assign in_win     = cpu_addr[CPU_AW-1:RAM_AW] == PAGE_W'(WIN_PAGE);
  assign contended  = !mreq_n && in_win;
  assign hold       = vid_req && contended;
  assign cpu_rise   = !cpu_clk && !hold;

  assign vid_gnt    = vid_req;
  assign ram_addr   = vid_req ? vid_addr : cpu_addr[RAM_AW-1:0];
  assign ram_we     = contended && !vid_req && !wr_n && rd_n;
  assign ram_wdata  = cpu_wdata;
  assign cpu_rdata  = ram_rdata;
  assign vid_rdata  = ram_rdata;

  assign io_sel     = !iorq_n && ((cpu_addr[7:0] & IO_MASK) == IO_MATCH);
  assign io_rd      = io_sel && !rd_n && wr_n;
  assign io_wr      = io_sel && !wr_n && rd_n;

  assign frame_tick = fcnt == FW'(FRAME_DIV - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpu_clk <= 1'b0;
    else        cpu_clk <= cpu_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fcnt <= '0;
    else if (frame_tick) fcnt <= '0;
    else                 fcnt <= fcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_n <= 1'b1;
      icnt  <= '0;
    end else if (frame_tick) begin
      int_n <= 1'b0;
      icnt  <= '0;
    end else if (!int_n && cpu_rise) begin
      if (icnt == IW'(INT_CYCLES - 1)) int_n <= 1'b1;
      icnt <= icnt + 1'b1;
    end
  end

  p_high_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk |=> !cpu_clk);

  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk && vid_req && !mreq_n && in_win) |=> !cpu_clk);

  p_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk && (mreq_n || !in_win)) |=> cpu_clk);

  p_resume_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk && !vid_req) |=> cpu_clk);

  p_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vid_req |-> (vid_gnt && !ram_we && ram_addr == vid_addr));

  p_rw_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !wr_n) |-> !(ram_we || io_rd || io_wr));

  p_io_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd || io_wr) |-> !iorq_n);

  p_len_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !int_n |-> icnt < IW'(INT_CYCLES));

endmodule

// File: tb/sim_shared_ram_arbiter.sv
module sim_shared_ram_arbiter;
  localparam int FDIV = 200;
  localparam int ICYC = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0, cpu_rdata, vid_rdata, ram_wdata, ram_rdata;
  logic mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, vid_req = 1'b0;
  logic [13:0] vid_addr = '0, ram_addr;
  logic cpu_clk, int_n, io_rd, io_wr, vid_gnt, ram_we;
  logic [7:0] mem [256];
  int unsigned runs = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ram_we) mem[ram_addr[7:0]] <= ram_wdata;
  end
  assign ram_rdata = mem[ram_addr[7:0]];

  shared_ram_arbiter #(.FRAME_DIV(FDIV), .INT_CYCLES(ICYC)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n),
    .wr_n(wr_n), .cpu_clk(cpu_clk), .int_n(int_n), .io_rd(io_rd), .io_wr(io_wr),
    .vid_req(vid_req), .vid_addr(vid_addr), .vid_gnt(vid_gnt),
    .vid_rdata(vid_rdata), .ram_addr(ram_addr), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_bus();
    mreq_n = 1; iorq_n = 1; rd_n = 1; wr_n = 1; vid_req = 0;
  endtask

  task automatic wait_clk_level(input logic lvl);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (cpu_clk == lvl) break;
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(cpu_clk == 0, "R1", "cpu_clk in reset", cpu_clk, 0);
    check(int_n == 1, "R1", "int_n in reset", int_n, 1);
    check(ram_we == 0, "R1", "ram_we in reset", ram_we, 0);
    rst_n = 1;
  endtask

  task automatic t_free();
    logic prev;
    bit ok = 1;
    @(negedge clk); prev = cpu_clk;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (cpu_clk == prev) ok = 0;
      prev = cpu_clk;
    end
    check(ok, "R2", "free-running toggle", ok, 1);
  endtask

  task automatic t_video();
    mem[8'h3C] = 8'h5A;
    @(negedge clk);
    vid_req = 1; vid_addr = 14'h123C;
    cpu_addr = 16'h4011; mreq_n = 0; wr_n = 0; cpu_wdata = 8'hEE;
    #1;
    check(vid_gnt == 1, "R3", "grant", vid_gnt, 1);
    check(ram_addr == 14'h123C, "R3", "ram_addr", ram_addr, 14'h123C);
    check(vid_rdata == 8'h5A, "R3", "vid_rdata", vid_rdata, 8'h5A);
    check(ram_we == 0, "R3", "cpu write blocked", ram_we, 0);
    idle_bus();
  endtask

  task automatic t_stall_low();
    bit ok = 1;
    wait_clk_level(0);
    cpu_addr = 16'h4123; mreq_n = 0; rd_n = 0; vid_req = 1; vid_addr = 14'h0001;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (cpu_clk != 0) ok = 0;
    end
    check(ok, "R4", "held low while contended", ok, 1);
    vid_req = 0;
    @(negedge clk);
    check(cpu_clk == 1, "R6", "resume after release", cpu_clk, 1);
    idle_bus();
  endtask

  task automatic t_stall_high();
    bit ok = 1;
    wait_clk_level(1);
    cpu_addr = 16'h7FFF; mreq_n = 0; rd_n = 0; vid_req = 1;
    @(negedge clk);
    check(cpu_clk == 0, "R4", "high phase ends on time", cpu_clk, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (cpu_clk != 0) ok = 0;
    end
    check(ok, "R4", "held after late contention", ok, 1);
    idle_bus();
    @(negedge clk);
  endtask

  task automatic t_no_contend();
    logic prev;
    bit ok = 1;
    cpu_addr = 16'h8000; mreq_n = 0; rd_n = 0; vid_req = 1;
    @(negedge clk); prev = cpu_clk;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (cpu_clk == prev) ok = 0;
      prev = cpu_clk;
    end
    check(ok, "R5", "outside window unstretched", ok, 1);
    ok = 1; cpu_addr = 16'h4000; mreq_n = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (cpu_clk == prev) ok = 0;
      prev = cpu_clk;
    end
    check(ok, "R5", "mreq_n high unstretched", ok, 1);
    idle_bus();
  endtask

  task automatic t_write_read();
    @(negedge clk);
    cpu_addr = 16'h4055; cpu_wdata = 8'hA5; mreq_n = 0; wr_n = 0;
    #1;
    check(ram_we == 1, "R7", "write enable", ram_we, 1);
    check(ram_addr == 14'h0055, "R7", "write address", ram_addr, 14'h0055);
    check(ram_wdata == 8'hA5, "R7", "write data", ram_wdata, 8'hA5);
    @(negedge clk);
    wr_n = 1; rd_n = 0;
    #1;
    check(cpu_rdata == 8'hA5, "R7", "read back", cpu_rdata, 8'hA5);
    idle_bus();
  endtask

  task automatic t_io();
    @(negedge clk);
    cpu_addr = 16'hABFE; iorq_n = 0; rd_n = 0;
    #1;
    check(io_rd == 1 && io_wr == 0, "R8", "io read selected", {io_rd, io_wr}, 2'b10);
    cpu_addr = 16'h12FE; #1;
    check(io_rd == 1, "R8", "upper byte ignored", io_rd, 1);
    cpu_addr = 16'hABFF; #1;
    check(io_rd == 0, "R8", "odd port not selected", io_rd, 0);
    cpu_addr = 16'h0010; rd_n = 1; wr_n = 0; #1;
    check(io_wr == 1 && io_rd == 0, "R8", "io write selected", {io_rd, io_wr}, 2'b01);
    iorq_n = 1; #1;
    check(io_wr == 0, "R8", "no strobe without iorq", io_wr, 0);
    idle_bus();
  endtask

  task automatic t_both_strobes();
    @(negedge clk);
    cpu_addr = 16'h4002; mreq_n = 0; rd_n = 0; wr_n = 0;
    #1;
    check(ram_we == 0, "R9", "no ram write on both strobes", ram_we, 0);
    mreq_n = 1; iorq_n = 0; cpu_addr = 16'h0002; #1;
    check(io_rd == 0 && io_wr == 0, "R9", "no io strobe on both", {io_rd, io_wr}, 0);
    idle_bus();
  endtask

  task automatic wait_int_fall(output int unsigned at);
    logic prev = int_n;
    at = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (prev && !int_n) begin at = cyc; break; end
      prev = int_n;
    end
  endtask

  task automatic t_interrupt();
    int unsigned t0, t1, rises = 0;
    logic pc, pi;
    wait_int_fall(t0);
    check(t0 != 0, "R10", "first interrupt seen", t0 != 0, 1);
    pc = cpu_clk; pi = int_n;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!pc && cpu_clk && !pi) rises++;
      pc = cpu_clk; pi = int_n;
      if (i == 6) begin cpu_addr = 16'h4100; mreq_n = 0; rd_n = 0; vid_req = 1; end
      if (i == 18) idle_bus();
      if (int_n) break;
    end
    idle_bus();
    check(rises == ICYC, "R11", "cpu rises in low pulse", rises, ICYC);
    wait_int_fall(t1);
    check(t1 - t0 == FDIV, "R10", "interrupt period", t1 - t0, FDIV);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    t_reset();
    t_free();
    t_video();
    t_stall_low();
    t_stall_high();
    t_no_contend();
    t_write_read();
    t_io();
    t_both_strobes();
    t_interrupt();
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #100000;
    runs++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule